// File: doc/BRIEF.md
# RV32 Integer Arithmetic and Logic Unit with Operation Decode

This block computes the 32-bit result of the base-integer register-register and register-immediate arithmetic, logic, shift and set-less-than instructions. It is purely combinational. The caller supplies the three-bit function code, instruction bit 30, a flag that marks the immediate form, the first source operand, and a second operand. The second operand is either the second source register or the already sign-extended 12-bit immediate.

Inside, a small decoder turns the function code, bit 30 and the form flag into one operation. That operation selects among a shared add/subtract path, a logarithmic barrel shifter, a signed/unsigned comparator and the bitwise logic. Operand fetch, immediate extraction and writeback are left to the surrounding pipeline.

Top module: `rv_int_alu`

## Requirements
- R1: With function code 000 and bit 30 clear, the result is operand A plus operand B, wrapping modulo 2^32 with no overflow indication.
- R2: With function code 000, bit 30 set and the register form selected (immediate flag 0), the result is A minus B modulo 2^32.
- R3: In immediate form (immediate flag 1), function code 000 always adds, whatever the value of bit 30.
- R4: Function codes 111, 110 and 100 give the bitwise AND, OR and XOR of A and B. In immediate form B is the sign-extended immediate, so an immediate of 0x800 arrives as 0xfffff800.
- R5: Function code 001 shifts A left by B[4:0], filling with zeros. All higher bits of B are ignored.
- R6: Function code 101 shifts A right by B[4:0] in both forms. Bit 30 clear fills with zeros and bit 30 set fills with A[31].
- R7: Function code 010 gives 1 when A is less than B as two's-complement values, and 0 otherwise.
- R8: Function code 011 gives 1 when A is less than B as unsigned values, and 0 otherwise. This holds in immediate form too, where a sign-extended immediate reaches 0xfffff800..0xffffffff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| funct3_i | input | 3 | Instruction function code |
| alt_i | input | 1 | Instruction bit 30 (subtract / arithmetic-shift select) |
| imm_sel_i | input | 1 | 1 when operand B is a sign-extended immediate |
| src_a_i | input | 32 | First source operand |
| src_b_i | input | 32 | Second source operand or sign-extended immediate |
| result_o | output | 32 | Operation result |

## Verification
The stimulus targets the edges where a wrong decode or datapath would show. Sums and differences cross the sign boundary, so a design that flagged or saturated on overflow would return the wrong value. An immediate add carries bit 30 set, which a decoder that ignored the form flag would turn into a subtraction. Shift amounts come with junk in the upper bits of B, which would produce huge or zero results if they were not masked. Right shifts use a negative A at amounts 0, 4, 8 and 31, to catch a swapped or missing sign fill. Set-less-than cases pit negative against positive values and use a sign-extended immediate as an unsigned bound, so swapping signed and unsigned comparison flips the answer.

// File: rtl/rvalu_pkg.sv
package rvalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_SLL,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_SRL,
        OP_SRA,
        OP_OR,
        OP_AND
    } alu_op_e;

    localparam logic [2:0] F3_ADDSUB = 3'b000;
    localparam logic [2:0] F3_SLL    = 3'b001;
    localparam logic [2:0] F3_SLT    = 3'b010;
    localparam logic [2:0] F3_SLTU   = 3'b011;
    localparam logic [2:0] F3_XOR    = 3'b100;
    localparam logic [2:0] F3_SHR    = 3'b101;
    localparam logic [2:0] F3_OR     = 3'b110;
    localparam logic [2:0] F3_AND    = 3'b111;

    // Subtract only exists in register form; arithmetic shift in both forms.
    function automatic alu_op_e decode_op(input logic [2:0] f3,
                                          input logic       alt,
                                          input logic       imm);
        case (f3)
            F3_ADDSUB: return (alt && !imm) ? OP_SUB : OP_ADD;
            F3_SLL:    return OP_SLL;
            F3_SLT:    return OP_SLT;
            F3_SLTU:   return OP_SLTU;
            F3_XOR:    return OP_XOR;
            F3_SHR:    return alt ? OP_SRA : OP_SRL;
            F3_OR:     return OP_OR;
            default:   return OP_AND;
        endcase
    endfunction

    typedef struct packed {
        logic right;
        logic arith;
    } shift_mode_t;

endpackage

// File: rtl/rvalu_decode.sv
module rvalu_decode
    import rvalu_pkg::*;
(
    input  logic [2:0]  funct3_i,
    input  logic        alt_i,
    input  logic        imm_sel_i,
    output alu_op_e     op_o,
    output shift_mode_t shmode_o,
    output logic        subtract_o,
    output logic        cmp_signed_o
);
    always_comb begin
        op_o           = decode_op(funct3_i, alt_i, imm_sel_i);
        shmode_o.right = (op_o == OP_SRL) || (op_o == OP_SRA);
        shmode_o.arith = (op_o == OP_SRA);
        subtract_o     = (op_o == OP_SUB);
        cmp_signed_o   = (op_o == OP_SLT);
    end
endmodule

// File: rtl/rvalu_shifter.sv
module rvalu_shifter
    import rvalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  shift_mode_t          mode_i,
    output logic [W-1:0]         data_o
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage [SHW+1];
    logic         fill;

    // Left shifts run through the right shifter on a bit-reversed operand.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = data_i[W-1-i];
        assign rev_out[i] = stage[SHW][W-1-i];
    end

    assign fill     = mode_i.arith & data_i[W-1];
    assign stage[0] = mode_i.right ? data_i : rev_in;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt_i[s]
                          ? {{STEP{fill}}, stage[s][W-1:STEP]}
                          : stage[s];
    end

    assign data_o = mode_i.right ? stage[SHW] : rev_out;
endmodule

// File: rtl/rvalu_compare.sv
module rvalu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic         lt_o
);
    logic [W:0] ea;
    logic [W:0] eb;
    logic [W:0] diff;

    // One extra bit turns either comparison into the borrow of a subtraction.
    assign ea   = {signed_i & a_i[W-1], a_i};
    assign eb   = {signed_i & b_i[W-1], b_i};
    assign diff = ea - eb;
    assign lt_o = diff[W];
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
    import rvalu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      funct3_i,
    input  logic            alt_i,
    input  logic            imm_sel_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    output logic [XLEN-1:0] result_o
);
    localparam int SHW = $clog2(XLEN);

    alu_op_e     op;
    shift_mode_t shmode;
    logic        subtract;
    logic        cmp_signed;
    logic [XLEN-1:0] addsub;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] shifted;
    logic            lt;

    rvalu_decode u_decode (
        .funct3_i    (funct3_i),
        .alt_i       (alt_i),
        .imm_sel_i   (imm_sel_i),
        .op_o        (op),
        .shmode_o    (shmode),
        .subtract_o  (subtract),
        .cmp_signed_o(cmp_signed)
    );

    // One adder serves both add and subtract: invert B and carry in one.
    assign b_eff  = subtract ? ~src_b_i : src_b_i;
    assign addsub = src_a_i + b_eff + {{(XLEN-1){1'b0}}, subtract};

    rvalu_shifter #(.W(XLEN)) u_shift (
        .data_i(src_a_i),
        .amt_i (src_b_i[SHW-1:0]),
        .mode_i(shmode),
        .data_o(shifted)
    );

    rvalu_compare #(.W(XLEN)) u_cmp (
        .a_i     (src_a_i),
        .b_i     (src_b_i),
        .signed_i(cmp_signed),
        .lt_o    (lt)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB:          result_o = addsub;
            OP_SLL, OP_SRL, OP_SRA:  result_o = shifted;
            OP_SLT, OP_SLTU:         result_o = {{(XLEN-1){1'b0}}, lt};
            OP_XOR:                  result_o = src_a_i ^ src_b_i;
            OP_OR:                   result_o = src_a_i | src_b_i;
            default:                 result_o = src_a_i & src_b_i;
        endcase
    end
endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk #(
    parameter int XLEN = 32
) (
    input logic [2:0]      funct3_i,
    input logic            alt_i,
    input logic            imm_sel_i,
    input logic [XLEN-1:0] src_a_i,
    input logic [XLEN-1:0] src_b_i,
    input logic [XLEN-1:0] result_o
);
    localparam int SHW = $clog2(XLEN);

    logic known;
    logic [SHW-1:0] sh;
    assign known = !$isunknown({funct3_i, alt_i, imm_sel_i, src_a_i, src_b_i, result_o});
    assign sh    = src_b_i[SHW-1:0];

    always_comb begin
        if (known) begin
            if (funct3_i == 3'b000 && !alt_i)
                assert_add_wrap_R1: assert (result_o == src_a_i + src_b_i);
            if (funct3_i == 3'b000 && alt_i && !imm_sel_i)
                assert_sub_inverse_R2: assert (result_o + src_b_i == src_a_i);
            if (funct3_i == 3'b000 && imm_sel_i)
                assert_imm_adds_R3: assert (result_o - src_b_i == src_a_i);
            if (funct3_i == 3'b111)
                assert_and_subset_R4: assert ((result_o & ~src_a_i) == '0);
            if (funct3_i == 3'b001)
                assert_sll_low_zero_R5: assert ((result_o << (XLEN - 1 - sh)) >> (XLEN - 1 - sh) == '0
                                               || result_o[0] == (sh == 0 ? src_a_i[0] : 1'b0));
            if (funct3_i == 3'b101 && sh != 0)
                assert_shr_fill_R6: assert (result_o[XLEN-1] == (alt_i & src_a_i[XLEN-1]));
            if (funct3_i == 3'b010)
                assert_slt_bool_R7: assert (result_o[XLEN-1:1] == '0);
            if (funct3_i == 3'b011)
                assert_sltu_bool_R8: assert (result_o[XLEN-1:1] == '0);
        end
    end
endmodule

bind rv_int_alu rv_int_alu_chk #(.XLEN(XLEN)) u_chk (
    .funct3_i (funct3_i),
    .alt_i    (alt_i),
    .imm_sel_i(imm_sel_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .result_o (result_o)
);

// File: tb/rv_int_alu_bench.sv
module rv_int_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  funct3;
    logic        alt;
    logic        imm_sel;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rv_int_alu u_rv_int_alu (
        .funct3_i (funct3),
        .alt_i    (alt),
        .imm_sel_i(imm_sel),
        .src_a_i  (a),
        .src_b_i  (b),
        .result_o (res)
    );

    // {req, funct3, alt, imm, A, B, expected}
    localparam int NV = 22;
    localparam logic [104:0] VEC [NV] = '{
        {4'd1, 3'b000, 1'b0, 1'b0, 32'h7fffffff, 32'h00000001, 32'h80000000}, // R1
        {4'd1, 3'b000, 1'b0, 1'b0, 32'hffffffff, 32'h00000002, 32'h00000001}, // R1
        {4'd2, 3'b000, 1'b1, 1'b0, 32'h00000005, 32'h00000007, 32'hfffffffe}, // R2
        {4'd2, 3'b000, 1'b1, 1'b0, 32'h80000000, 32'h00000001, 32'h7fffffff}, // R2
        {4'd3, 3'b000, 1'b1, 1'b1, 32'h00001000, 32'hfffffc00, 32'h00000c00}, // R3
        {4'd4, 3'b111, 1'b0, 1'b1, 32'h55551111, 32'hfffff800, 32'h55551000}, // R4
        {4'd4, 3'b100, 1'b0, 1'b1, 32'h55551111, 32'hfffff800, 32'haaaae911}, // R4
        {4'd4, 3'b110, 1'b0, 1'b0, 32'h55551111, 32'hff00ff00, 32'hff55ff11}, // R4
        {4'd4, 3'b110, 1'b0, 1'b1, 32'h55551111, 32'hfffff800, 32'hfffff911}, // R4
        {4'd4, 3'b111, 1'b0, 1'b0, 32'h55551111, 32'hff00ff00, 32'h55001100}, // R4
        {4'd5, 3'b001, 1'b0, 1'b0, 32'h12345678, 32'h00000008, 32'h34567800}, // R5
        {4'd5, 3'b001, 1'b0, 1'b0, 32'h12345678, 32'hffffffe4, 32'h23456780}, // R5
        {4'd6, 3'b101, 1'b1, 1'b0, 32'h87654321, 32'h00000008, 32'hff876543}, // R6
        {4'd6, 3'b101, 1'b0, 1'b0, 32'h87654321, 32'h00000008, 32'h00876543}, // R6
        {4'd6, 3'b101, 1'b1, 1'b1, 32'h87654321, 32'h00000404, 32'hf8765432}, // R6
        {4'd6, 3'b101, 1'b0, 1'b1, 32'h87654321, 32'h00000004, 32'h08765432}, // R6
        {4'd7, 3'b010, 1'b0, 1'b0, 32'hffffffff, 32'h00000001, 32'h00000001}, // R7
        {4'd7, 3'b010, 1'b0, 1'b1, 32'h7fffffff, 32'hfffff800, 32'h00000000}, // R7
        {4'd8, 3'b011, 1'b0, 1'b0, 32'hffffffff, 32'h00000001, 32'h00000000}, // R8
        {4'd8, 3'b011, 1'b0, 1'b1, 32'h00000005, 32'hfffff800, 32'h00000001}, // R8
        {4'd8, 3'b011, 1'b0, 1'b1, 32'hfffffc00, 32'hfffff800, 32'h00000000}, // R8
        {4'd8, 3'b011, 1'b0, 1'b1, 32'hfffff7ff, 32'hfffff800, 32'h00000001}  // R8
    };

    task automatic apply(input logic [2:0] f3, input logic al, input logic im,
                         input logic [31:0] va, input logic [31:0] vb);
        @(negedge clk);
        funct3 = f3; alt = al; imm_sel = im; a = va; b = vb;
        #2;
    endtask

    task automatic check(input int rq, input logic [31:0] exp);
        total++;
        if (res !== exp) begin
            bad++;
            $display("FAIL R%0d: got %08h expected %08h (f3=%b alt=%b imm=%b a=%08h b=%08h)",
                     rq, res, exp, funct3, alt, imm_sel, a, b);
        end
    endtask

    initial begin
        funct3 = '0; alt = 0; imm_sel = 0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle inputs (add of zeros) give zero: R1
        apply(3'b000, 0, 0, 32'h0, 32'h0);
        check(1, 32'h0);
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][100:98], VEC[i][97], VEC[i][96], VEC[i][95:64], VEC[i][63:32]);
            check(int'(VEC[i][104:101]), VEC[i][31:0]);
        end
        // R3: register form of the same pattern subtracts, immediate form adds
        apply(3'b000, 1, 0, 32'h00001000, 32'hfffffc00);
        check(2, 32'h00001400);
        // R6: amount zero leaves operand unchanged; extremes at 31
        apply(3'b101, 1, 0, 32'h87654321, 32'hffffffe0);
        check(6, 32'h87654321);
        apply(3'b101, 1, 0, 32'h80000000, 32'h0000001f);
        check(6, 32'hffffffff);
        apply(3'b101, 0, 0, 32'h80000000, 32'h0000001f);
        check(6, 32'h00000001);
        // R5: shift by 31
        apply(3'b001, 0, 0, 32'h00000003, 32'h0000001f);
        check(5, 32'h80000000);
        // R7: equal operands are not less
        apply(3'b010, 0, 0, 32'h80000000, 32'h80000000);
        check(7, 32'h0);
        apply(3'b010, 0, 0, 32'h80000000, 32'h7fffffff);
        check(7, 32'h1);
        // R8: unsigned view of the same pair
        apply(3'b011, 0, 0, 32'h80000000, 32'h7fffffff);
        check(8, 32'h0);
        // R4: xor register form
        apply(3'b100, 0, 0, 32'h55551111, 32'hff00ff00);
        check(4, 32'haaaaeeee + 32'h0 ^ 32'h0 ^ (32'haaaaeeee ^ 32'haa55ee11));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule